// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each cycle the surrounding sequencer may present the accumulator, a second operand byte (an immediate, a scratchpad byte or a byte fetched from memory), a 4-bit operation code and the current 5-bit status word. One clock later the block returns the byte the operation produced and the new status word. Fetch, memory sequencing and interrupt control belong to other blocks. The only part of interrupt control here is that the interrupt-enable bit passes through unchanged.

Each operation class follows its own fixed flag rule. Some classes update all four arithmetic flags. Logic ops and left shifts clear overflow and carry. Right shifts also force the sign flag high. Loads leave the whole status word alone. The sign flag has positive polarity: it reads 1 when bit 7 of the result is 0. For the decrement operation the produced byte is the decremented operand, which the sequencer writes back to the scratchpad. For the compare operation the produced byte is the unchanged accumulator.

Top module: `acc_alu_core`

## Requirements
- R1: The status word holds the interrupt enable in bit 4, overflow in bit 3, zero in bit 2, carry in bit 1 and sign in bit 0. Bit 4 of `stat_out` always equals bit 4 of the `stat_in` that came with the operation.
- R2: `res_valid` rises exactly one clock after `op_valid` is sampled high. A synchronous reset clears `res_valid`, `res_out` and `stat_out` to zero.
- R3: Code 0 (add) yields A+operand. Code 1 (link) yields A+carry flag. Code 2 (increment) yields A+1. Carry is the carry out of bit 7, and overflow is the two's-complement signed overflow.
- R4: Every operation that updates flags sets zero when the flag byte is 0x00. Every such operation except a right shift sets sign when bit 7 of the flag byte is 0. The flag byte is the result, or the difference for compare.
- R5: Code 3 (decimal add) adds packed BCD digits. A digit whose raw sum exceeds 9 gets 6 added and passes a carry on. Carry is the high-digit carry. Overflow is the signed overflow of the plain binary sum.
- R6: Codes 4, 5, 6 and 7 yield AND, OR, XOR and complement (A XOR 0xFF). Each clears overflow and carry.
- R7: Code 8 (compare) sets all four arithmetic flags from operand + NOT(A) + 1 and returns A unchanged.
- R8: Code 9 (decrement) returns operand + 0xFF and sets all four arithmetic flags from that addition.
- R9: Codes 10 (right by one) and 12 (right by four) shift A right and fill with zeros. They clear overflow and carry and force sign to 1.
- R10: Codes 11 (left by one) and 13 (left by four) shift A left and fill with zeros. They clear overflow and carry.
- R11: Code 14 (load) returns the operand. Code 15 (reserved) returns A. Both leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 4 | Operation code |
| acc_in | input | DATA_W | Accumulator value |
| opnd_in | input | DATA_W | Second operand byte |
| stat_in | input | 5 | Current status word |
| res_valid | output | 1 | Result registered from the previous cycle |
| res_out | output | DATA_W | Byte produced by the operation |
| stat_out | output | 5 | New status word |

## Verification
Some properties are checked on every result cycle. These are the pass-through of the interrupt-enable bit, the one-cycle latency, the zero flag against the returned byte, positive sign polarity, the flags forced by logic ops and right shifts, the unchanged accumulator on compare, and the untouched status word on load.

Other behaviour only the bench sweeps can show: the exact sums, the carry and overflow values, the BCD digit correction, the carry-in for link, and the compare flags. The sweeps compare these against an integer model across a grid of operand pairs, with carry both set and clear, plus directed BCD, decrement and compare corner values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int STAT_W = 5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_LINK = 4'd1,
        OP_INC  = 4'd2,
        OP_DADD = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CPL  = 4'd7,
        OP_CMP  = 4'd8,
        OP_DEC  = 4'd9,
        OP_SHR1 = 4'd10,
        OP_SHL1 = 4'd11,
        OP_SHR4 = 4'd12,
        OP_SHL4 = 4'd13,
        OP_LOAD = 4'd14,
        OP_RSVD = 4'd15
    } alu_op_e;

    // bit order follows the status word: ie, ovf, zero, carry, pos
    typedef struct packed {
        logic ie;
        logic ovf;
        logic zero;
        logic carry;
        logic pos;
    } stat_t;

    typedef enum logic [1:0] {
        FL_KEEP,
        FL_ARITH,
        FL_LOGIC,
        FL_SHR
    } flag_rule_e;

    typedef enum logic [2:0] {
        SRC_SUM,
        SRC_BCD,
        SRC_LU,
        SRC_OPND,
        SRC_ACC
    } res_src_e;

    typedef struct packed {
        flag_rule_e rule;
        res_src_e   src;
        logic       flag_from_sum;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(alu_op_e op);
        op_ctl_t c;
        c.flag_from_sum = 1'b0;
        unique case (op)
            OP_ADD, OP_LINK, OP_INC, OP_DEC: begin
                c.rule = FL_ARITH; c.src = SRC_SUM;
            end
            OP_DADD: begin
                c.rule = FL_ARITH; c.src = SRC_BCD;
            end
            OP_CMP: begin
                c.rule = FL_ARITH; c.src = SRC_ACC; c.flag_from_sum = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL, OP_SHL1, OP_SHL4: begin
                c.rule = FL_LOGIC; c.src = SRC_LU;
            end
            OP_SHR1, OP_SHR4: begin
                c.rule = FL_SHR; c.src = SRC_LU;
            end
            OP_LOAD: begin
                c.rule = FL_KEEP; c.src = SRC_OPND;
            end
            default: begin
                c.rule = FL_KEEP; c.src = SRC_ACC;
            end
        endcase
        return c;
    endfunction

    function automatic stat_t merge_flags(flag_rule_e rule, stat_t prev,
                                          logic ovf, logic carry,
                                          logic zero, logic pos);
        stat_t s;
        s = prev;
        unique case (rule)
            FL_ARITH: begin
                s.ovf = ovf; s.carry = carry; s.zero = zero; s.pos = pos;
            end
            FL_LOGIC: begin
                s.ovf = 1'b0; s.carry = 1'b0; s.zero = zero; s.pos = pos;
            end
            FL_SHR: begin
                s.ovf = 1'b0; s.carry = 1'b0; s.zero = zero; s.pos = 1'b1;
            end
            default: s = prev;
        endcase
        s.ie = prev.ie;
        return s;
    endfunction

endpackage

// File: rtl/acc_bin_adder.sv
module acc_bin_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] low;
    logic [W:0]   full;

    // carry into the top bit comes from the lower W-1 bits
    assign low  = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin};
    assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};

    assign sum  = full[W-1:0];
    assign cout = full[W];
    assign ovf  = low[W-1] ^ full[W];
endmodule

// File: rtl/acc_bcd_digit.sv
module acc_bcd_digit (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       ci,
    output logic [3:0] d,
    output logic       co
);
    logic [4:0] raw;

    assign raw = {1'b0, a} + {1'b0, b} + {4'b0, ci};
    assign co  = (raw > 5'd9);
    assign d   = co ? (raw[3:0] + 4'd6) : raw[3:0];
endmodule

// File: rtl/acc_bcd_adder.sv
module acc_bcd_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NDIG = W / 4;

    logic [NDIG:0] chain;
    assign chain[0] = 1'b0;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        acc_bcd_digit u_dig (
            .a  (a[4*g +: 4]),
            .b  (b[4*g +: 4]),
            .ci (chain[g]),
            .d  (sum[4*g +: 4]),
            .co (chain[g+1])
        );
    end

    assign cout = chain[NDIG];
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
    import acc_alu_pkg::*;
#(
    parameter int W        = 8,
    parameter int SH_SMALL = 1,
    parameter int SH_BIG   = 4
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~a;
            OP_SHR1: res = a >> SH_SMALL;
            OP_SHL1: res = a << SH_SMALL;
            OP_SHR4: res = a >> SH_BIG;
            OP_SHL4: res = a << SH_BIG;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [STAT_W-1:0] stat_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_out,
    output logic [STAT_W-1:0] stat_out
);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    alu_op_e op_e;
    op_ctl_t ctl;
    stat_t   st_prev;
    stat_t   st_next;

    assign op_e    = alu_op_e'(op_sel);
    assign ctl     = decode_op(op_e);
    assign st_prev = stat_t'(stat_in);

    logic [DATA_W-1:0] add_x, add_y, add_sum;
    logic              add_cin, add_cout, add_ovf;

    always_comb begin
        add_x   = acc_in;
        add_y   = opnd_in;
        add_cin = 1'b0;
        unique case (op_e)
            OP_LINK: begin add_y = '0; add_cin = st_prev.carry; end
            OP_INC:  begin add_y = '0; add_cin = 1'b1; end
            OP_CMP:  begin add_x = opnd_in; add_y = ~acc_in; add_cin = 1'b1; end
            OP_DEC:  begin add_x = opnd_in; add_y = ALL_ONES; end
            default: ;
        endcase
    end

    acc_bin_adder #(.W(DATA_W)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    logic [DATA_W-1:0] bcd_sum;
    logic              bcd_cout;

    acc_bcd_adder #(.W(DATA_W)) u_bcd (
        .a    (acc_in),
        .b    (opnd_in),
        .sum  (bcd_sum),
        .cout (bcd_cout)
    );

    logic [DATA_W-1:0] lu_res;

    acc_logic_unit #(.W(DATA_W)) u_lu (
        .op  (op_e),
        .a   (acc_in),
        .b   (opnd_in),
        .res (lu_res)
    );

    logic [DATA_W-1:0] res_d;
    logic [DATA_W-1:0] flag_byte;
    logic              carry_d;

    always_comb begin
        unique case (ctl.src)
            SRC_SUM:  res_d = add_sum;
            SRC_BCD:  res_d = bcd_sum;
            SRC_LU:   res_d = lu_res;
            SRC_OPND: res_d = opnd_in;
            default:  res_d = acc_in;
        endcase
        flag_byte = ctl.flag_from_sum ? add_sum : res_d;
        carry_d   = (ctl.src == SRC_BCD) ? bcd_cout : add_cout;
        st_next   = merge_flags(ctl.rule, st_prev, add_ovf, carry_d,
                                (flag_byte == '0), ~flag_byte[DATA_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_out   <= '0;
            stat_out  <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_out  <= res_d;
                stat_out <= st_next;
            end
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic [STAT_W-1:0] stat_in,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_out,
    input logic [STAT_W-1:0] stat_out
);
    // R1
    ie_hold_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> stat_out[4] == $past(stat_in[4]));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid) == res_valid);

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) != OP_LOAD && $past(op_sel) != OP_RSVD
         && $past(op_sel) != OP_CMP)
        |-> stat_out[2] == (res_out == '0));

    // R4
    pos_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) != OP_LOAD && $past(op_sel) != OP_RSVD
         && $past(op_sel) != OP_CMP && $past(op_sel) != OP_SHR1
         && $past(op_sel) != OP_SHR4)
        |-> stat_out[0] == ~res_out[DATA_W-1]);

    // R6
    logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) >= OP_AND && $past(op_sel) <= OP_CPL)
        |-> stat_out[3:1] == {1'b0, 1'b0, 1'b0} | {1'b0, stat_out[2], 1'b0});

    // R9
    shr_force_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ($past(op_sel) == OP_SHR1 || $past(op_sel) == OP_SHR4))
        |-> (stat_out[0] && !stat_out[3] && !stat_out[1]));

    // R7
    cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) == OP_CMP) |-> res_out == $past(acc_in));

    // R11
    load_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(op_sel) == OP_LOAD)
        |-> (stat_out == $past(stat_in) && res_out == $past(opnd_in)));
endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .stat_in   (stat_in),
    .res_valid (res_valid),
    .res_out   (res_out),
    .stat_out  (stat_out)
);

// File: tb/acc_alu_core_tb_top.sv
`timescale 1ns/1ps
module acc_alu_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [4:0] stat_in = '0;
    logic       res_valid;
    logic [7:0] res_out;
    logic [4:0] stat_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    acc_alu_core #(.DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .stat_in(stat_in),
        .res_valid(res_valid), .res_out(res_out), .stat_out(stat_out)
    );

    function automatic int sg(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // returns {result, ie, ovf, zero, carry, sign}
    function automatic logic [12:0] model(int op, int a, int b, logic [4:0] st);
        int r = 0, fv, s = 0, rule = 1;
        bit c = 0, v, z, p;
        case (op)
            0:  begin r = a + b; c = r > 255; s = sg(a) + sg(b); end
            1:  begin r = a + int'(st[1]); c = r > 255; s = sg(a) + int'(st[1]); end
            2:  begin r = a + 1; c = r > 255; s = sg(a) + 1; end
            3:  begin
                    int lo, hi; bit lc;
                    lo = (a % 16) + (b % 16);
                    lc = lo > 9; if (lc) lo += 6;
                    hi = (a / 16) + (b / 16) + int'(lc);
                    c = hi > 9; if (c) hi += 6;
                    r = (hi % 16) * 16 + (lo % 16);
                    s = sg(a) + sg(b);
                end
            4:  begin r = a & b; rule = 2; end
            5:  begin r = a | b; rule = 2; end
            6:  begin r = a ^ b; rule = 2; end
            7:  begin r = 255 - a; rule = 2; end
            8:  begin r = b + (255 - a) + 1; c = r > 255; s = sg(b) - sg(a); end
            9:  begin r = b + 255; c = r > 255; s = sg(b) - 1; end
            10: begin r = a / 2; rule = 3; end
            11: begin r = (a * 2) % 256; rule = 2; end
            12: begin r = a / 16; rule = 3; end
            13: begin r = (a * 16) % 256; rule = 2; end
            14: begin r = b; rule = 0; end
            default: begin r = a; rule = 0; end
        endcase
        r  = r % 256;
        fv = r;
        if (op == 8) r = a;
        v = (s > 127) || (s < -128);
        z = (fv == 0);
        p = (fv < 128);
        case (rule)
            0: return {r[7:0], st};
            1: return {r[7:0], st[4], v, z, c, p};
            2: return {r[7:0], st[4], 1'b0, z, 1'b0, p};
            default: return {r[7:0], st[4], 1'b0, z, 1'b0, 1'b1};
        endcase
    endfunction

    function automatic string req_of(int op);
        case (op)
            0, 1, 2:        return "R3";
            3:              return "R5";
            4, 5, 6, 7:     return "R6";
            8:              return "R7";
            9:              return "R8";
            10, 12:         return "R9";
            11, 13:         return "R10";
            default:        return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(int op, int a, int b, logic [4:0] st);
        logic [12:0] e;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op[3:0]; acc_in = a[7:0];
        opnd_in = b[7:0]; stat_in = st;
        e = model(op, a, b, st);
        @(negedge clk);
        // R2: registered one cycle after the inputs
        check("R2", "valid", int'(res_valid), 1);
        check(req_of(op), "result", int'(res_out), int'(e[12:5]));
        check(req_of(op), "ovf/carry", int'({stat_out[3], stat_out[1]}),
              int'({e[3], e[1]}));
        // R4: zero and sign
        check("R4", "zero/sign", int'({stat_out[2], stat_out[0]}),
              int'({e[2], e[0]}));
        // R1: interrupt enable passes through
        check("R1", "ie", int'(stat_out[4]), int'(e[4]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", "reset valid", int'(res_valid), 0);
        check("R2", "reset result", int'(res_out), 0);
        check("R2", "reset status", int'(stat_out), 0);
        rst = 1'b0;

        for (int op = 0; op < 16; op++)
            for (int si = 0; si < 2; si++)
                for (int a = 0; a < 256; a += 15)
                    for (int b = 0; b < 256; b += 15)
                        run_vec(op, a, b, (si == 0) ? 5'b10010 : 5'b01101);

        // directed corners
        run_vec(3, 8'h99, 8'h01, 5'b00000);  // R5 decimal wrap to 00 with carry
        run_vec(3, 8'h45, 8'h38, 5'b10000);  // R5 low digit correction
        run_vec(8, 8'h5A, 8'h5A, 5'b00000);  // R7 equal compare
        run_vec(8, 8'h01, 8'h00, 5'b00000);  // R7 borrow
        run_vec(9, 8'h00, 8'h00, 5'b00000);  // R8 decrement from zero
        run_vec(9, 8'h00, 8'h80, 5'b00000);  // R8 signed overflow
        run_vec(1, 8'hFF, 8'h00, 5'b00010);  // R3 link with carry set wraps
        run_vec(2, 8'h7F, 8'h00, 5'b00000);  // R3 increment overflow
        run_vec(10, 8'h01, 8'h00, 5'b11111); // R9 shift to zero
        run_vec(13, 8'h0F, 8'h00, 5'b00000); // R10 nibble moves into sign
        run_vec(15, 8'h3C, 8'hC3, 5'b10101); // R11 reserved

        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        // R2: no valid without an operation
        check("R2", "idle valid", int'(res_valid), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule